// File: doc/BRIEF.md
# Unibus DMA Address Mapper

This block sits between a 16-bit DMA device and a memory built from 36-bit words. A DMA command gives an 18-bit Unibus byte address, a byte count, a byte-or-word size and a direction. The block walks the transfer one element at a time. For each element it turns the Unibus address into a memory word address through a per-page mapping table. It then reads the 36-bit word. A read element has its 8-bit or 16-bit lane extracted and returned. A write element has the new data merged into the word, and the word is written back.

Software loads the mapping table through a simple write port. Each entry holds a valid flag and a physical page number. When an element cannot be mapped, or when memory reports that the word does not exist, the transfer stops. A sticky timeout flag is raised, and the completion report gives the number of bytes still outstanding.

Top module: `udma_mapper`

## Requirements
- R1: After reset, `cmd_ready` is 1, and `tmo`, `done_valid`, `rd_valid` and `wr_ready` are 0. Every map entry is invalid, so the first element of any transfer is rejected.
- R2: A map write with `map_idx` below MAP_DEPTH (48) stores `map_wvalid` and `map_page` in that entry and replaces its previous contents. A map write with a larger index changes no entry.
- R3: For each element, word index = byte address >> 2, page index = word index >> 9, and offset = word index[8:0]. `mem_addr` = entry page * 512 + offset.
- R4: An element is rejected if its page index is 48 or more, if address bit 17 is set, or if its entry is invalid. On a rejection no memory access is made for it, `tmo` is set, and the transfer ends with `done_left` = bytes not yet transferred, counting the rejected element.
- R5: If `mem_nxm` is 1 together with the read data of an element, the element is treated as rejected as in R4. Nothing is written for it.
- R6: A byte element uses the 8-bit lane at shift 18, 26, 0 or 8 for address bits [1:0] = 0, 1, 2 or 3. The byte is returned zero-extended on `rd_data`.
- R7: A word element uses the 16-bit lane at shift 18 when address bit 1 is 0, and at shift 0 when it is 1.
- R8: A word write replaces only the selected 16-bit lane (bits 33:18 or 15:0). Bits 35:34, and the other 18-bit half, keep their value.
- R9: A byte write replaces only the selected 8 bits. All other 28 bits of the word keep their value.
- R10: In word mode, bit 0 of the start address and of the count is forced to 0. A command whose effective count is 0 completes with `done_left` = 0 and makes no memory access.
- R11: Each accepted command produces exactly one one-cycle `done_valid` pulse, with `done_left` = 0 on success. `cmd_ready` is 0 from the cycle after acceptance until the cycle after that pulse. `rd_valid` and `wr_ready` are never 1 together.
- R12: `tmo` stays 1 until a cycle with `tmo_clr` = 1 and no new rejection. A rejection in the same cycle as `tmo_clr` wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| map_we | input | 1 | Map entry write strobe |
| map_idx | input | 6 | Map entry index |
| map_wvalid | input | 1 | Valid flag to store |
| map_page | input | 11 | Physical page number to store |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted when both are high |
| cmd_addr | input | 18 | Unibus start byte address |
| cmd_count | input | 18 | Byte count |
| cmd_byte | input | 1 | 1 = byte elements, 0 = 16-bit elements |
| cmd_write | input | 1 | 1 = device to memory |
| wr_valid | input | 1 | Write element data offered |
| wr_ready | output | 1 | Write element taken |
| wr_data | input | 16 | Write element data (byte mode uses [7:0]) |
| rd_valid | output | 1 | Read element available |
| rd_ready | input | 1 | Read element taken |
| rd_data | output | 16 | Read element data |
| done_valid | output | 1 | One-cycle transfer completion |
| done_left | output | 18 | Bytes not transferred |
| tmo | output | 1 | Sticky timeout flag |
| tmo_clr | input | 1 | Clears the timeout flag |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 20 | Memory word address |
| mem_wdata | output | 36 | Merged word to write |
| mem_rdata | input | 36 | Read word, one cycle after a read request |
| mem_nxm | input | 1 | Non-existent memory, alongside mem_rdata |

## Verification
Word and byte transfers are run over all four byte offsets against words holding distinct patterns, so that a wrong shift for any lane returns a different value. Writes are checked against a full memory image after each transfer. This shows that neighbour lanes and the two top bits of each word survive the merge. Transfers that cross a page boundary into an invalid entry, into an entry pointing past memory, into an index at or beyond 48, and above address bit 17 separate the four rejection causes, and they check the reported remaining count. Odd word-mode starts and counts, zero-length commands, writes to indexes out of range, and a later invalidating rewrite of an entry cover the edges of command decoding and table loading.

// File: rtl/udma_pkg.sv
package udma_pkg;

  localparam int WORD_W = 36;
  localparam int HALF_W = 16;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MAP,
    ST_CHK,
    ST_MRD,
    ST_MWT,
    ST_RD,
    ST_WR
  } xfer_state_e;

  // Bit position of the selected lane inside the 36-bit word.
  function automatic logic [5:0] lane_shift(input logic is_byte, input logic [1:0] lo);
    logic [5:0] sh;
    if (is_byte) begin
      case (lo)
        2'd0:    sh = 6'd18;
        2'd1:    sh = 6'd26;
        2'd2:    sh = 6'd0;
        default: sh = 6'd8;
      endcase
    end else begin
      sh = lo[1] ? 6'd0 : 6'd18;
    end
    return sh;
  endfunction

endpackage

// File: rtl/udma_map_ram.sv
module udma_map_ram #(
  parameter int MAP_DEPTH = 48,
  parameter int PPN_W     = 11,
  localparam int IDX_W    = $clog2(MAP_DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic             wvalid,
  input  logic [PPN_W-1:0] wpage,
  input  logic [IDX_W-1:0] raddr,
  output logic             rvalid,
  output logic [PPN_W-1:0] rpage
);

  localparam logic [IDX_W:0] DEPTH_LIM = (IDX_W+1)'(MAP_DEPTH);

  logic [PPN_W-1:0]     page_mem [MAP_DEPTH];
  logic [MAP_DEPTH-1:0] vld_q;
  logic                 wr_ok;

  assign wr_ok = we && ({1'b0, widx} < DEPTH_LIM);

  // Page numbers: plain RAM, no reset, registered read port.
  always_ff @(posedge clk) begin
    if (wr_ok) page_mem[widx] <= wpage;
    rpage <= page_mem[raddr];
  end

  // Valid flags live in flops so that reset can clear all of them.
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= '0;
      rvalid <= 1'b0;
    end else begin
      if (wr_ok) vld_q[widx] <= wvalid;
      rvalid <= vld_q[raddr];
    end
  end

  AST_MAP_OOR_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (we && !wr_ok) |=> $stable(vld_q)); // R2

  AST_MAP_FLAG_LOADED: assert property (@(posedge clk) disable iff (rst)
    wr_ok |=> (vld_q[$past(widx)] == $past(wvalid))); // R2

endmodule

// File: rtl/udma_lane.sv
module udma_lane
  import udma_pkg::*;
(
  input  logic [WORD_W-1:0] word_in,
  input  logic [1:0]        addr_lo,
  input  logic              is_byte,
  input  logic [HALF_W-1:0] wdata,
  output logic [HALF_W-1:0] rdata,
  output logic [WORD_W-1:0] merged
);

  logic [5:0]        sh;
  logic [WORD_W-1:0] width_mask;
  logic [WORD_W-1:0] lane_mask;
  logic [WORD_W-1:0] wide_w;

  always_comb begin
    sh         = lane_shift(is_byte, addr_lo);
    width_mask = is_byte ? WORD_W'({BYTE_W{1'b1}}) : WORD_W'({HALF_W{1'b1}});
    lane_mask  = width_mask << sh;
    rdata      = HALF_W'((word_in >> sh) & width_mask);
    wide_w     = (WORD_W'(wdata) & width_mask) << sh;
    merged     = (word_in & ~lane_mask) | wide_w;
  end

endmodule

// File: rtl/udma_xfer_ctl.sv
module udma_xfer_ctl
  import udma_pkg::*;
#(
  parameter int UADDR_W   = 18,
  parameter int OFF_W     = 9,
  parameter int PPN_W     = 11,
  parameter int MAP_DEPTH = 48,
  localparam int IDX_W    = $clog2(MAP_DEPTH),
  localparam int VPN_W    = UADDR_W - 2 - OFF_W,
  localparam int PA_W     = PPN_W + OFF_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [UADDR_W-1:0] cmd_addr,
  input  logic [UADDR_W-1:0] cmd_count,
  input  logic               cmd_byte,
  input  logic               cmd_write,
  input  logic               wr_valid,
  output logic               wr_ready,
  input  logic [HALF_W-1:0]  wr_data,
  output logic               rd_valid,
  input  logic               rd_ready,
  output logic [HALF_W-1:0]  rd_data,
  output logic               done_valid,
  output logic [UADDR_W-1:0] done_left,
  output logic               tmo,
  input  logic               tmo_clr,
  output logic [IDX_W-1:0]   map_raddr,
  input  logic               map_rvalid,
  input  logic [PPN_W-1:0]   map_rpage,
  output logic               mem_req,
  output logic               mem_we,
  output logic [PA_W-1:0]    mem_addr,
  output logic [WORD_W-1:0]  mem_wdata,
  input  logic [WORD_W-1:0]  mem_rdata,
  input  logic               mem_nxm
);

  localparam logic [VPN_W:0] DEPTH_LIM = (VPN_W+1)'(MAP_DEPTH);

  xfer_state_e        state_q;
  logic [UADDR_W-1:0] addr_q, left_q, done_left_q;
  logic               byte_q, write_q, done_q, tmo_q;
  logic [WORD_W-1:0]  word_q;
  logic               mem_req_q, mem_we_q;
  logic [PA_W-1:0]    mem_addr_q;
  logic [WORD_W-1:0]  mem_wdata_q;

  logic [UADDR_W-3:0] widx;
  logic [VPN_W-1:0]   vpn;
  logic [OFF_W-1:0]   woff;
  logic               in_range, reject, fail, adv;
  logic [UADDR_W-1:0] step, left_nxt, cmd_left;
  logic [HALF_W-1:0]  lane_rdata;
  logic [WORD_W-1:0]  lane_merged;

  // Address decomposition of the current element.
  always_comb begin
    widx      = addr_q[UADDR_W-1:2];
    vpn       = widx[UADDR_W-3:OFF_W];
    woff      = widx[OFF_W-1:0];
    in_range  = ({1'b0, vpn} < DEPTH_LIM);
    map_raddr = in_range ? IDX_W'(vpn) : '0;
    reject    = !in_range || addr_q[UADDR_W-1] || !map_rvalid;
    step      = byte_q ? UADDR_W'(1) : UADDR_W'(2);
    left_nxt  = left_q - step;
    cmd_left  = cmd_byte ? cmd_count : {cmd_count[UADDR_W-1:1], 1'b0};
    fail      = ((state_q == ST_CHK) && reject) || ((state_q == ST_MWT) && mem_nxm);
    adv       = ((state_q == ST_RD) && rd_ready) || ((state_q == ST_WR) && wr_valid);
  end

  udma_lane u_lane (
    .word_in (word_q),
    .addr_lo (addr_q[1:0]),
    .is_byte (byte_q),
    .wdata   (wr_data),
    .rdata   (lane_rdata),
    .merged  (lane_merged)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      addr_q      <= '0;
      left_q      <= '0;
      byte_q      <= 1'b0;
      write_q     <= 1'b0;
      word_q      <= '0;
      done_q      <= 1'b0;
      done_left_q <= '0;
      tmo_q       <= 1'b0;
      mem_req_q   <= 1'b0;
      mem_we_q    <= 1'b0;
      mem_addr_q  <= '0;
      mem_wdata_q <= '0;
    end else begin
      done_q    <= 1'b0;
      mem_req_q <= 1'b0;
      mem_we_q  <= 1'b0;
      if (tmo_clr) tmo_q <= 1'b0;

      case (state_q)
        ST_IDLE: begin
          if (cmd_valid && cmd_ready) begin
            addr_q  <= cmd_byte ? cmd_addr : {cmd_addr[UADDR_W-1:1], 1'b0};
            left_q  <= cmd_left;
            byte_q  <= cmd_byte;
            write_q <= cmd_write;
            if (cmd_left == '0) begin
              done_q      <= 1'b1;
              done_left_q <= '0;
            end else begin
              state_q <= ST_MAP;
            end
          end
        end
        ST_MAP: state_q <= ST_CHK;
        ST_CHK: begin
          if (!reject) begin
            mem_req_q  <= 1'b1;
            mem_addr_q <= {map_rpage, woff};
            state_q    <= ST_MRD;
          end
        end
        ST_MRD: state_q <= ST_MWT;
        ST_MWT: begin
          if (!mem_nxm) begin
            word_q  <= mem_rdata;
            state_q <= write_q ? ST_WR : ST_RD;
          end
        end
        ST_WR: begin
          if (wr_valid) begin
            mem_req_q   <= 1'b1;
            mem_we_q    <= 1'b1;
            mem_wdata_q <= lane_merged;
          end
        end
        default: ;
      endcase

      if (fail) begin
        tmo_q       <= 1'b1;
        done_q      <= 1'b1;
        done_left_q <= left_q;
        state_q     <= ST_IDLE;
      end

      if (adv) begin
        addr_q <= addr_q + step;
        left_q <= left_nxt;
        if (left_nxt == '0) begin
          done_q      <= 1'b1;
          done_left_q <= '0;
          state_q     <= ST_IDLE;
        end else begin
          state_q <= ST_MAP;
        end
      end
    end
  end

  assign cmd_ready  = (state_q == ST_IDLE) && !done_q;
  assign rd_valid   = (state_q == ST_RD);
  assign wr_ready   = (state_q == ST_WR);
  assign rd_data    = lane_rdata;
  assign done_valid = done_q;
  assign done_left  = done_left_q;
  assign tmo        = tmo_q;
  assign mem_req    = mem_req_q;
  assign mem_we     = mem_we_q;
  assign mem_addr   = mem_addr_q;
  assign mem_wdata  = mem_wdata_q;

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done_valid |=> !done_valid); // R11

  AST_BUSY_AFTER_CMD: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready) |=> !cmd_ready); // R11

  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(rd_valid && wr_ready)); // R11

  AST_TMO_STICKY: assert property (@(posedge clk) disable iff (rst)
    (tmo && !tmo_clr) |=> tmo); // R12

  AST_TMO_MEANS_ABORT: assert property (@(posedge clk) disable iff (rst)
    $rose(tmo) |-> (done_valid && (done_left != '0))); // R4

  AST_NO_MEM_ON_ABORT: assert property (@(posedge clk) disable iff (rst)
    (done_valid && (done_left != '0)) |-> !mem_req); // R4

  AST_WORD_LEFT_EVEN: assert property (@(posedge clk) disable iff (rst)
    (done_valid && !byte_q) |-> !done_left[0]); // R10

endmodule

// File: rtl/udma_mapper.sv
module udma_mapper
  import udma_pkg::*;
#(
  parameter int UADDR_W   = 18,
  parameter int OFF_W     = 9,
  parameter int PPN_W     = 11,
  parameter int MAP_DEPTH = 48,
  localparam int IDX_W    = $clog2(MAP_DEPTH),
  localparam int PA_W     = PPN_W + OFF_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               map_we,
  input  logic [IDX_W-1:0]   map_idx,
  input  logic               map_wvalid,
  input  logic [PPN_W-1:0]   map_page,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [UADDR_W-1:0] cmd_addr,
  input  logic [UADDR_W-1:0] cmd_count,
  input  logic               cmd_byte,
  input  logic               cmd_write,
  input  logic               wr_valid,
  output logic               wr_ready,
  input  logic [HALF_W-1:0]  wr_data,
  output logic               rd_valid,
  input  logic               rd_ready,
  output logic [HALF_W-1:0]  rd_data,
  output logic               done_valid,
  output logic [UADDR_W-1:0] done_left,
  output logic               tmo,
  input  logic               tmo_clr,
  output logic               mem_req,
  output logic               mem_we,
  output logic [PA_W-1:0]    mem_addr,
  output logic [WORD_W-1:0]  mem_wdata,
  input  logic [WORD_W-1:0]  mem_rdata,
  input  logic               mem_nxm
);

  logic [IDX_W-1:0] map_raddr;
  logic             map_rvalid;
  logic [PPN_W-1:0] map_rpage;

  udma_map_ram #(
    .MAP_DEPTH (MAP_DEPTH),
    .PPN_W     (PPN_W)
  ) u_map (
    .clk    (clk),
    .rst    (rst),
    .we     (map_we),
    .widx   (map_idx),
    .wvalid (map_wvalid),
    .wpage  (map_page),
    .raddr  (map_raddr),
    .rvalid (map_rvalid),
    .rpage  (map_rpage)
  );

  udma_xfer_ctl #(
    .UADDR_W   (UADDR_W),
    .OFF_W     (OFF_W),
    .PPN_W     (PPN_W),
    .MAP_DEPTH (MAP_DEPTH)
  ) u_xfer (
    .clk        (clk),
    .rst        (rst),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .cmd_addr   (cmd_addr),
    .cmd_count  (cmd_count),
    .cmd_byte   (cmd_byte),
    .cmd_write  (cmd_write),
    .wr_valid   (wr_valid),
    .wr_ready   (wr_ready),
    .wr_data    (wr_data),
    .rd_valid   (rd_valid),
    .rd_ready   (rd_ready),
    .rd_data    (rd_data),
    .done_valid (done_valid),
    .done_left  (done_left),
    .tmo        (tmo),
    .tmo_clr    (tmo_clr),
    .map_raddr  (map_raddr),
    .map_rvalid (map_rvalid),
    .map_rpage  (map_rpage),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_rdata  (mem_rdata),
    .mem_nxm    (mem_nxm)
  );

endmodule

// File: tb/test_udma_mapper.sv
module test_udma_mapper;

  localparam int MEM_WORDS = 2048;
  localparam int DEPTH     = 48;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        map_we = 1'b0;
  logic [5:0]  map_idx = '0;
  logic        map_wvalid = 1'b0;
  logic [10:0] map_page = '0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [17:0] cmd_addr = '0;
  logic [17:0] cmd_count = '0;
  logic        cmd_byte = 1'b0;
  logic        cmd_write = 1'b0;
  logic        wr_valid = 1'b1;
  logic        wr_ready;
  logic [15:0] wr_data = '0;
  logic        rd_valid;
  logic        rd_ready = 1'b1;
  logic [15:0] rd_data;
  logic        done_valid;
  logic [17:0] done_left;
  logic        tmo;
  logic        tmo_clr = 1'b0;
  logic        mem_req, mem_we;
  logic [19:0] mem_addr;
  logic [35:0] mem_wdata;
  logic [35:0] mem_rdata = '0;
  logic        mem_nxm = 1'b0;

  always #10 clk = ~clk;

  udma_mapper i_udma_mapper (
    .clk(clk), .rst(rst), .map_we(map_we), .map_idx(map_idx),
    .map_wvalid(map_wvalid), .map_page(map_page),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
    .cmd_count(cmd_count), .cmd_byte(cmd_byte), .cmd_write(cmd_write),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .done_valid(done_valid), .done_left(done_left), .tmo(tmo), .tmo_clr(tmo_clr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_nxm(mem_nxm)
  );

  logic [35:0] mem     [MEM_WORDS];
  logic [35:0] ref_mem [MEM_WORDS];
  bit          ref_vld [DEPTH];
  int          ref_pg  [DEPTH];

  logic [15:0] exp_rd_q [$];
  logic [15:0] wr_q     [$];
  int          exp_left;
  bit          exp_tmo;
  string       cur_tag;
  int          done_cnt = 0;
  int          n_chk = 0;
  int          n_fail = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  // Memory model: one-cycle read latency, nxm above MEM_WORDS.
  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) begin
        if (mem_addr < MEM_WORDS) mem[mem_addr] <= mem_wdata;
      end else begin
        mem_rdata <= (mem_addr < MEM_WORDS) ? mem[mem_addr] : '0;
        mem_nxm   <= (mem_addr >= MEM_WORDS);
      end
    end
  end

  // Write-data feeder: presents the next element while wr_ready is high.
  always @(negedge clk) begin
    if (wr_ready && wr_q.size() > 0) wr_data = wr_q.pop_front();
  end

  // Monitor: read elements and completions against the scoreboard.
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (exp_rd_q.size() == 0) chk(1'b0, {cur_tag, " unexpected read"}, rd_data, 0);
      else begin
        logic [15:0] e;
        e = exp_rd_q.pop_front();
        chk(rd_data == e, {cur_tag, " read data"}, rd_data, e);
      end
    end
    if (!rst && done_valid) begin
      chk(done_left == 18'(exp_left), {cur_tag, " done_left"}, done_left, exp_left);
      chk(tmo == exp_tmo, {cur_tag, " tmo at done"}, tmo, exp_tmo);
      done_cnt++;
    end
  end

  function automatic int lane_sh(input int a, input bit isb);
    if (isb) begin
      case (a & 3)
        0: return 18;
        1: return 26;
        2: return 0;
        default: return 8;
      endcase
    end
    return ((a & 2) != 0) ? 0 : 18;
  endfunction

  // Returns 1 when the element is rejected (R4, R5).
  function automatic bit xlate(input int a, output int pa);
    int w, vpn;
    w   = a >> 2;
    vpn = w >> 9;
    pa  = 0;
    if ((a & 'h20000) != 0) return 1'b1;
    if (vpn >= DEPTH) return 1'b1;
    if (!ref_vld[vpn]) return 1'b1;
    pa = ref_pg[vpn] * 512 + (w & 511);
    return (pa >= MEM_WORDS);
  endfunction

  task automatic map_set(input int idx, input bit v, input int pg);
    @(negedge clk);
    map_we = 1'b1; map_idx = 6'(idx); map_wvalid = v; map_page = 11'(pg);
    @(negedge clk);
    map_we = 1'b0;
    if (idx < DEPTH) begin ref_vld[idx] = v; ref_pg[idx] = pg; end
  endtask

  task automatic run_xfer(input string tag, input int addr, input int count,
                          input bit isb, input bit isw, input int seed);
    int a, left, step, pa, sh, n, bad;
    bit failed;
    logic [35:0] m;
    logic [15:0] d;
    @(negedge clk); tmo_clr = 1'b1;
    @(negedge clk); tmo_clr = 1'b0;
    chk(tmo == 1'b0, "R12 cleared", tmo, 0);
    a = isb ? addr : (addr & ~1);
    left = isb ? count : (count & ~1);
    step = isb ? 1 : 2;
    failed = 1'b0;
    m = isb ? 36'hFF : 36'hFFFF;
    while (left > 0) begin
      if (xlate(a, pa)) begin failed = 1'b1; break; end
      sh = lane_sh(a, isb);
      if (isw) begin
        d = 16'(seed + a * 311);
        if (isb) d = d & 16'h00FF;
        wr_q.push_back(d);
        ref_mem[pa] = (ref_mem[pa] & ~(m << sh)) | ((36'(d) & m) << sh);
      end else begin
        exp_rd_q.push_back(16'((ref_mem[pa] >> sh) & m));
      end
      a += step;
      left -= step;
    end
    exp_left = left;
    exp_tmo  = failed;
    cur_tag  = tag;
    n = done_cnt;
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_addr = 18'(addr); cmd_count = 18'(count);
    cmd_byte = isb; cmd_write = isw;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(cmd_ready == 1'b0, "R11 busy after accept", cmd_ready, 0);
    wait (done_cnt != n);
    @(negedge clk);
    chk(done_valid == 1'b0, "R11 single done pulse", done_valid, 0);
    chk(exp_rd_q.size() == 0 && wr_q.size() == 0, {tag, " all elements moved"},
        exp_rd_q.size() + wr_q.size(), 0);
    bad = 0;
    for (int i = 0; i < MEM_WORDS; i++) if (mem[i] !== ref_mem[i]) bad++;
    chk(bad == 0, {tag, " memory image"}, bad, 0);
  endtask

  initial begin
    for (int i = 0; i < MEM_WORDS; i++) begin
      logic [11:0] k;
      k = 12'(i);
      mem[i] = {k, ~k, k ^ 12'hA5C};
      ref_mem[i] = mem[i];
    end
    for (int i = 0; i < DEPTH; i++) begin ref_vld[i] = 1'b0; ref_pg[i] = 0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(cmd_ready == 1'b1, "R1 cmd_ready", cmd_ready, 1);
    chk(tmo == 1'b0, "R1 tmo", tmo, 0);
    chk(done_valid == 1'b0 && rd_valid == 1'b0 && wr_ready == 1'b0, "R1 idle outputs",
        {done_valid, rd_valid, wr_ready}, 0);
    run_xfer("R1 empty map", 0, 4, 1'b0, 1'b0, 0);
    // R12: flag holds until cleared
    repeat (3) @(negedge clk);
    chk(tmo == 1'b1, "R12 sticky", tmo, 1);

    map_set(0, 1'b1, 1);
    map_set(1, 1'b1, 2);
    map_set(2, 1'b1, 5);
    map_set(47, 1'b1, 0);
    map_set(50, 1'b1, 3);     // R2: index out of range, no effect

    run_xfer("R7 R3 word read", 0, 8, 1'b0, 1'b0, 0);
    run_xfer("R6 byte read", 'h10, 8, 1'b1, 1'b0, 0);
    run_xfer("R8 word write", 'h20, 6, 1'b0, 1'b1, 'h5A3C);
    run_xfer("R8 word readback", 'h20, 6, 1'b0, 1'b0, 0);
    run_xfer("R9 byte write", 'h41, 5, 1'b1, 1'b1, 'h0C7);
    run_xfer("R9 byte readback", 'h40, 8, 1'b1, 1'b0, 0);
    run_xfer("R10 odd word start", 'h81, 5, 1'b0, 1'b0, 0);
    run_xfer("R10 word count one", 'h90, 1, 1'b0, 1'b0, 0);
    run_xfer("R10 byte count zero", 'h90, 0, 1'b1, 1'b1, 0);
    run_xfer("R3 page crossing", 2044, 8, 1'b0, 1'b0, 0);
    run_xfer("R5 nxm mid transfer", 4092, 8, 1'b0, 1'b0, 0);
    run_xfer("R4 invalid entry write", 3 * 2048, 3, 1'b1, 1'b1, 'h77);
    run_xfer("R3 last entry", 47 * 2048 + 6, 4, 1'b0, 1'b0, 0);
    run_xfer("R2 R4 index past depth", 50 * 2048, 2, 1'b0, 1'b0, 0);
    run_xfer("R4 address bit 17", 'h20000, 2, 1'b1, 1'b0, 0);

    // R12: rejection in the same cycle as clear keeps the flag set
    @(negedge clk);
    cmd_valid = 1'b1; cmd_addr = 18'(3 * 2048); cmd_count = 18'd2;
    cmd_byte = 1'b0; cmd_write = 1'b0;
    exp_left = 2; exp_tmo = 1'b1; cur_tag = "R12 set beats clear";
    @(negedge clk);
    cmd_valid = 1'b0;
    @(negedge clk);           // element is in its check cycle
    tmo_clr = 1'b1;
    @(negedge clk);
    tmo_clr = 1'b0;
    chk(tmo == 1'b1, "R12 set beats clear", tmo, 1);

    map_set(0, 1'b0, 1);
    run_xfer("R2 entry invalidated", 0, 2, 1'b0, 1'b0, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule